// File: doc/BRIEF.md
# Tranche Loss Mapper and Per-Step Accumulator

This block sits at the end of a Monte Carlo credit pricing pipeline. For every path it receives a stream of collateral pool losses, one per time step, each tagged with its time-step index; the last sample of a path carries an end-of-path marker. Each pool loss is clamped against the tranche's attachment and detachment levels into a tranche loss. The tranche loss is then added into a wide accumulator kept for that time step, so the sums grow across all paths of a run.

A host programs the two tranche levels, pulses a clear before a run, streams the samples, and then reads back, through a combinational read port, one sum per time step together with the count of finished paths. Averaging over paths, discounting, and building the premium leg from the tranche width minus the tranche loss are left to the host. The mapping takes two pipeline stages; the accumulate takes a third edge. A sum that would pass the top of the accumulator range stays at full scale and raises a sticky overflow flag.

Top module: `tranche_loss_accum`

## Requirements
- R1: A pool loss at or below the attachment level contributes a tranche loss of zero.
- R2: A pool loss at or above the detachment level contributes the full tranche width, detachment minus attachment.
- R3: A pool loss strictly between the two levels contributes pool loss minus attachment.
- R4: Each accepted sample (inValid high, clear low) adds its tranche loss into the accumulator selected by inStep. rdSum shows the accumulator at rdAddr, with no clock delay. The new sum first appears after the third rising edge counted from the edge that accepted the sample.
- R5: pathCount rises by exactly one for each accepted sample that has inLast high, on the same edge as that sample's accumulate.
- R6: A clear zeroes every accumulator, pathCount and overflow on its edge. Samples accepted on the clear edge, and samples still inside the pipeline, are discarded.
- R7: A sum above 2^ACC_W-1 stays at 2^ACC_W-1 and sets overflow. Overflow stays set until a clear or a reset.
- R8: Attachment and detachment are loaded from cfgAttach and cfgDetach on an edge where cfgWe is high. Software must keep detachment at or above attachment. The new levels apply to samples accepted on later edges.
- R9: After reset, every accumulator, pathCount, overflow and both tranche levels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of sums, count and flag; flushes the pipeline |
| cfgWe | input | 1 | Loads the tranche levels |
| cfgAttach | input | LOSS_W | Attachment level to load |
| cfgDetach | input | LOSS_W | Detachment level to load |
| inValid | input | 1 | Pool loss sample present |
| inLoss | input | LOSS_W | Pool loss, unsigned fixed point |
| inStep | input | STEP_W | Time-step index of the sample |
| inLast | input | 1 | Sample is the last of its path |
| rdAddr | input | STEP_W | Time step to read |
| rdSum | output | ACC_W | Accumulated tranche loss of step rdAddr |
| pathCount | output | CNT_W | Paths finished since the last clear |
| overflow | output | 1 | Sticky saturation flag |

## Verification
Two things can happen on the same edge: a clear can arrive while samples are still inside the two mapping stages or are being accepted, and a saturating add can land together with an end-of-path count. The bench sends a sample and then raises clear on the next edge, while also offering a new sample on that edge. It then expects every sum and the count to stay zero. It also drives more than 4096 full-width losses into one step, each closing a path. It expects the sum to stop at full scale, the flag to be set and the count to still reach the exact number of paths. The flag must then survive a later normal add.

// File: rtl/tla_pkg.sv
`timescale 1ns/1ps
package tla_pkg;
  // strobes from control to datapath, one per action in a cycle
  typedef struct packed {
    logic clrAll;   // wipe sums, count, flag
    logic ld1;      // capture a sample into mapping stage 1
    logic ld2;      // advance stage 1 into stage 2
    logic accEn;    // add stage 2 result into its step accumulator
    logic pathEnd;  // count one finished path
  } tla_strobe_t;
endpackage

// File: rtl/tla_ctrl.sv
`timescale 1ns/1ps
module tla_ctrl
  import tla_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        inValid,
  input  logic        inLast,
  output tla_strobe_t stb
);
  logic v1, v2, last1, last2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; last1 <= 1'b0; last2 <= 1'b0;
    end else if (clear) begin
      v1 <= 1'b0; v2 <= 1'b0; last1 <= 1'b0; last2 <= 1'b0;
    end else begin
      v1    <= inValid;
      last1 <= inValid & inLast;
      v2    <= v1;
      last2 <= last1;
    end
  end

  always_comb begin
    stb.clrAll  = clear;
    stb.ld1     = inValid & ~clear;
    stb.ld2     = v1 & ~clear;
    stb.accEn   = v2 & ~clear;
    stb.pathEnd = v2 & last2 & ~clear;
  end
endmodule

// File: rtl/tla_datapath.sv
`timescale 1ns/1ps
module tla_datapath
  import tla_pkg::*;
#(
  parameter int LOSS_W = 42,
  parameter int ACC_W  = 54,
  parameter int NSTEP  = 32,
  parameter int CNT_W  = 32,
  localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tla_strobe_t       stb,
  input  logic              cfgWe,
  input  logic [LOSS_W-1:0] cfgAttach,
  input  logic [LOSS_W-1:0] cfgDetach,
  input  logic [LOSS_W-1:0] inLoss,
  input  logic [STEP_W-1:0] inStep,
  input  logic [STEP_W-1:0] rdAddr,
  output logic [ACC_W-1:0]  rdSum,
  output logic [CNT_W-1:0]  pathCount,
  output logic              overflow
);
  localparam logic [ACC_W:0] SAT_MAX = {1'b0, {ACC_W{1'b1}}};
  localparam int PAD_W = ACC_W + 1 - LOSS_W;

  logic [LOSS_W-1:0] attachQ, detachQ;
  logic [LOSS_W-1:0] excess1, width1, tl2;
  logic [STEP_W-1:0] step1, step2;
  logic [ACC_W-1:0]  accMem [NSTEP];
  logic [ACC_W:0]    sumWide;

  // tranche levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attachQ <= '0; detachQ <= '0;
    end else if (cfgWe) begin
      attachQ <= cfgAttach; detachQ <= cfgDetach;
    end
  end

  // stage 1: loss above attachment, and tranche width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excess1 <= '0; width1 <= '0; step1 <= '0;
    end else if (stb.ld1) begin
      excess1 <= (inLoss > attachQ) ? (inLoss - attachQ) : '0;
      width1  <= detachQ - attachQ;
      step1   <= inStep;
    end
  end

  // stage 2: cap at tranche width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tl2 <= '0; step2 <= '0;
    end else if (stb.ld2) begin
      tl2   <= (excess1 > width1) ? width1 : excess1;
      step2 <= step1;
    end
  end

  assign sumWide = {1'b0, accMem[step2]} + {{PAD_W{1'b0}}, tl2};

  // per-step accumulators with saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSTEP; i++) accMem[i] <= '0;
      overflow <= 1'b0;
    end else if (stb.clrAll) begin
      for (int i = 0; i < NSTEP; i++) accMem[i] <= '0;
      overflow <= 1'b0;
    end else if (stb.accEn) begin
      if (sumWide > SAT_MAX) begin
        accMem[step2] <= {ACC_W{1'b1}};
        overflow      <= 1'b1;
      end else begin
        accMem[step2] <= sumWide[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pathCount <= '0;
    else if (stb.clrAll)    pathCount <= '0;
    else if (stb.pathEnd)   pathCount <= pathCount + 1'b1;
  end

  assign rdSum = (int'(rdAddr) < NSTEP) ? accMem[rdAddr] : '0;
endmodule

// File: rtl/tranche_loss_accum.sv
`timescale 1ns/1ps
module tranche_loss_accum
  import tla_pkg::*;
#(
  parameter int LOSS_W = 42,
  parameter int ACC_W  = 54,
  parameter int NSTEP  = 32,
  parameter int CNT_W  = 32,
  localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              cfgWe,
  input  logic [LOSS_W-1:0] cfgAttach,
  input  logic [LOSS_W-1:0] cfgDetach,
  input  logic              inValid,
  input  logic [LOSS_W-1:0] inLoss,
  input  logic [STEP_W-1:0] inStep,
  input  logic              inLast,
  input  logic [STEP_W-1:0] rdAddr,
  output logic [ACC_W-1:0]  rdSum,
  output logic [CNT_W-1:0]  pathCount,
  output logic              overflow
);
  tla_strobe_t stb;

  tla_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear),
    .inValid(inValid), .inLast(inLast), .stb(stb)
  );

  tla_datapath #(
    .LOSS_W(LOSS_W), .ACC_W(ACC_W), .NSTEP(NSTEP), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgWe(cfgWe), .cfgAttach(cfgAttach), .cfgDetach(cfgDetach),
    .inLoss(inLoss), .inStep(inStep), .rdAddr(rdAddr),
    .rdSum(rdSum), .pathCount(pathCount), .overflow(overflow)
  );
endmodule

// File: rtl/tla_checker.sv
`timescale 1ns/1ps
module tla_checker #(
  parameter int LOSS_W = 42,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              cfgWe,
  input logic [LOSS_W-1:0] cfgAttach,
  input logic [LOSS_W-1:0] cfgDetach,
  input logic              inValid,
  input logic              inLast,
  input logic [CNT_W-1:0]  pathCount,
  input logic              overflow
);
  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (pathCount == '0 && !overflow)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (pathCount == $past(pathCount) || pathCount == $past(pathCount) + 1'b1)); // R5

  AST_COUNT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid && inLast && !clear, 2) && $past(!clear) && !clear)
      |=> pathCount == $past(pathCount) + 1'b1); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clear) |=> overflow); // R7

  AST_CFG_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> cfgDetach >= cfgAttach); // R8
endmodule

bind tranche_loss_accum tla_checker #(.LOSS_W(LOSS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .cfgWe(cfgWe),
  .cfgAttach(cfgAttach), .cfgDetach(cfgDetach), .inValid(inValid),
  .inLast(inLast), .pathCount(pathCount), .overflow(overflow)
);

// File: tb/tranche_loss_accum_bench.sv
`timescale 1ns/1ps
module tranche_loss_accum_bench;
  localparam int LOSS_W = 42;
  localparam int ACC_W  = 54;
  localparam int NSTEP  = 32;
  localparam int CNT_W  = 32;
  localparam int STEP_W = $clog2(NSTEP);
  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0, cfgWe = 1'b0;
  logic [LOSS_W-1:0] cfgAttach = '0, cfgDetach = '0, inLoss = '0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [STEP_W-1:0] inStep = '0, rdAddr = '0;
  logic [ACC_W-1:0] rdSum;
  logic [CNT_W-1:0] pathCount;
  logic overflow;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [ACC_W-1:0]  expSum [NSTEP];
  logic [CNT_W-1:0]  expCnt;
  logic              expOvf;
  logic [LOSS_W-1:0] mAtt, mDet;

  always #4 clk = ~clk;

  tranche_loss_accum #(.LOSS_W(LOSS_W), .ACC_W(ACC_W), .NSTEP(NSTEP), .CNT_W(CNT_W))
  u_tranche_loss_accum (
    .clk(clk), .rstN(rstN), .clear(clear), .cfgWe(cfgWe),
    .cfgAttach(cfgAttach), .cfgDetach(cfgDetach), .inValid(inValid),
    .inLoss(inLoss), .inStep(inStep), .inLast(inLast), .rdAddr(rdAddr),
    .rdSum(rdSum), .pathCount(pathCount), .overflow(overflow)
  );

  function automatic logic [LOSS_W-1:0] trLoss(logic [LOSS_W-1:0] l, a, d);
    if (l <= a) return '0;
    if (l >= d) return d - a;
    return l - a;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < NSTEP; i++) expSum[i] = '0;
    expCnt = '0; expOvf = 1'b0;
  endtask

  task automatic modelAdd(int s, logic [LOSS_W-1:0] l, bit last);
    logic [ACC_W:0] w;
    w = {1'b0, expSum[s]} + (ACC_W+1)'(trLoss(l, mAtt, mDet));
    if (w > {1'b0, FULL}) begin expSum[s] = FULL; expOvf = 1'b1; end
    else expSum[s] = w[ACC_W-1:0];
    if (last) expCnt = expCnt + 1'b1;
  endtask

  task automatic setCfg(logic [LOSS_W-1:0] a, logic [LOSS_W-1:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAttach = a; cfgDetach = d;
    @(negedge clk); cfgWe = 1'b0;
    mAtt = a; mDet = d;
  endtask

  task automatic send(int s, logic [LOSS_W-1:0] l, bit last);
    @(negedge clk);
    inValid = 1'b1; inLoss = l; inStep = STEP_W'(s); inLast = last;
    modelAdd(s, l, last);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); inValid = 1'b0; inLast = 1'b0; end
  endtask

  task automatic clearPulse();
    @(negedge clk); inValid = 1'b0; clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    modelClear();
  endtask

  task automatic checkAll(string req);
    for (int i = 0; i < NSTEP; i++) begin
      rdAddr = STEP_W'(i); #1;
      chk(req, 64'(rdSum), 64'(expSum[i]));
    end
    chk({req, " count"}, 64'(pathCount), 64'(expCnt));
    chk({req, " ovf"}, 64'(overflow), 64'(expOvf));
  endtask

  initial begin
    void'($urandom(32'd2024));
    modelClear(); mAtt = '0; mDet = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    checkAll("R9");
    rstN = 1'b1;
    // R9: zero levels give zero width, so contribution is zero
    send(1, 42'd500, 1'b1); idle(4);
    checkAll("R9 levels");

    // R1 R2 R3 boundaries, attach 100 detach 300
    clearPulse();
    setCfg(42'd100, 42'd300);
    send(0, 42'd0, 1'b0);   // R1
    send(1, 42'd99, 1'b0);  // R1
    send(2, 42'd100, 1'b0); // R1 at attachment
    send(3, 42'd101, 1'b0); // R3
    send(4, 42'd299, 1'b0); // R3
    send(5, 42'd300, 1'b0); // R2 at detachment
    send(6, 42'd301, 1'b0); // R2
    send(7, {LOSS_W{1'b1}}, 1'b1); // R2
    send(3, 42'd250, 1'b1); // R4 second add to same step
    idle(4);
    rdAddr = 1; #1; chk("R1", 64'(rdSum), 64'd0);
    rdAddr = 2; #1; chk("R1 edge", 64'(rdSum), 64'd0);
    rdAddr = 4; #1; chk("R3", 64'(rdSum), 64'd199);
    rdAddr = 6; #1; chk("R2", 64'(rdSum), 64'd200);
    rdAddr = 3; #1; chk("R4 same step", 64'(rdSum), 64'd151);
    checkAll("R1 R2 R3");

    // R4 latency: visible only after the third edge
    rdAddr = 9;
    send(9, 42'd180, 1'b1);
    idle(1); #1;
    chk("R4 lat1", 64'(rdSum), 64'd0);
    @(negedge clk); #1;
    chk("R4 lat2", 64'(rdSum), 64'd0);
    @(negedge clk); #1;
    chk("R4 lat3", 64'(rdSum), 64'd80);
    idle(2);
    checkAll("R4 R5");

    // R8: new levels apply to later samples
    setCfg(42'd50, 42'd60);
    send(10, 42'd200, 1'b0); idle(4);
    rdAddr = 10; #1; chk("R8", 64'(rdSum), 64'd10);

    // R6 collision: clear while a sample is in flight and another is offered
    send(11, 42'd70, 1'b1);
    @(negedge clk); clear = 1'b1; inValid = 1'b1; inLoss = 42'd55; inStep = 12; inLast = 1'b1;
    @(negedge clk); clear = 1'b0; inValid = 1'b0; inLast = 1'b0;
    modelClear();
    idle(4);
    checkAll("R6");

    // R7 saturation with path counting on the same edges
    setCfg(42'd0, {LOSS_W{1'b1}});
    for (int k = 0; k < 4097; k++) send(5, {LOSS_W{1'b1}}, 1'b1);
    idle(4);
    rdAddr = 5; #1; chk("R7 sat", 64'(rdSum), 64'(FULL));
    chk("R7 flag", 64'(overflow), 64'd1);
    chk("R5 count", 64'(pathCount), 64'd4097);
    send(6, 42'd3, 1'b0); idle(4);
    chk("R7 sticky", 64'(overflow), 64'd1);
    checkAll("R7");
    clearPulse(); #1;
    chk("R6 flag", 64'(overflow), 64'd0);

    // random run
    for (int r = 0; r < 4; r++) begin
      logic [LOSS_W-1:0] a, d;
      clearPulse();
      a = LOSS_W'($urandom_range(0, 1 << 20));
      d = a + LOSS_W'($urandom_range(0, 1 << 21));
      setCfg(a, d);
      for (int k = 0; k < 300; k++) begin
        send(int'($urandom_range(0, NSTEP-1)), LOSS_W'($urandom_range(0, 1 << 22)),
             bit'($urandom_range(0, 3) == 0));
        if ($urandom_range(0, 4) == 0) idle(1);
      end
      idle(4);
      checkAll("R4 R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule